// File: doc/BRIEF.md
# SDIO Extended Command Frame Generator

This block issues the 48-bit extended read/write command (index 53) of an SDIO host on the serial command line. When it is started, it captures a command descriptor: direction, I/O function number, block or byte mode, address increment, a 17-bit register address and a 9-bit count. From these it builds the frame and its CRC7 in one step and shifts the frame out most significant bit first. The frame is wrapped in one idle clock on each side. The block then waits a bounded number of clocks for the card's response start bit. It checks only that a response is present and skips its content.

For a write in block mode, the block then drives the 4-bit data bus. The function number selects one of two fixed block sizes. A prefetching byte port supplies the payload, which goes out high nibble first. Each block is framed by a start nibble and an end nibble. After each block, data line 0 is released and the card's 3-bit status token is sampled on it. Consecutive blocks are separated by two idle clocks. A single `done` pulse with an `err` flag closes each transaction. One bus bit is sent per clock of `clk`.

Top module: `sdio_xcmd_gen`

## Requirements
- R1: The command frame is bits 47..0, sent bit 47 first: bit 47 = 0 (start), bit 46 = 1 (host direction), bits 45:40 = 53, bit 39 = write flag, bits 38:36 = function number, bit 35 = block mode, bit 34 = increment, bits 33:17 = address, bits 16:8 = count, bits 7:1 = CRC7, bit 0 = 1 (stop).
- R2: The CRC7 is the remainder of bits 47..8 under the polynomial x^7+x^3+1, computed with the register initially zero.
- R3: `cmd_oe` is high for exactly 50 consecutive clocks per command: one clock at 1, the 48 frame bits, then one clock at 1.
- R4: If `cmd_i` shows no 0 start bit within RESP_TIMEOUT clocks after the command, the transaction ends with `done` and `err` high, and the data lines are never driven.
- R5: A read, or a write in byte mode, ends with `done` high and `err` low once the response start bit is seen, and no data phase follows.
- R6: For a block write, all four data lines are driven to 1 (`dat_oe`=1111) for one clock before the first block. Each block is then a start nibble 0000, the payload bytes as high nibble then low nibble, and an end nibble 1111.
- R7: The block length is BLK_F2 bytes when the function number is 2, and BLK_F1 bytes for any other function.
- R8: After each end nibble, `dat_oe` becomes 1110 and a 0 start bit followed by three token bits (first received = MSB) is awaited on `dat0_i`. Token 010 accepts the block. Any other token, or no start bit within ACK_TIMEOUT clocks, ends the transaction with `err` high.
- R9: Between consecutive blocks, all four lines are driven to 1 for exactly two clocks.
- R10: After the last accepted block, and whenever `done` is high, `dat_oe` is 0000. A fully accepted block write ends with `err` low.
- R11: A block-mode write with count 0 sends no frame and gives `done` and `err` high in the clock after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transaction using the descriptor inputs (ignored while busy) |
| d_wr | input | 1 | Direction: 1 write, 0 read |
| d_func | input | 3 | I/O function number |
| d_blk | input | 1 | 1 block mode, 0 byte mode |
| d_inc | input | 1 | Incrementing address |
| d_addr | input | 17 | Register address |
| d_cnt | input | 9 | Block or byte count |
| pl_data | input | 8 | Next payload byte, valid while pl_rd is high |
| pl_rd | output | 1 | Payload byte taken at the coming clock edge |
| cmd_i | input | 1 | Command line as received |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| dat0_i | input | 1 | Data line 0 as received |
| dat_o | output | 4 | Data line drive values |
| dat_oe | output | 4 | Data line output enables, one per line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Error flag, valid with done |

## Verification
The bench builds the block with BLK_F1=4, BLK_F2=8, RESP_TIMEOUT=12 and ACK_TIMEOUT=10. With four- and eight-byte blocks, a three-block write, its inter-block gaps and a token rejection in the middle block all fit in a few hundred clocks. With different lengths per function, a wrong size selection shows up as a byte or end-nibble mismatch. The short timeouts make the missing-response and missing-token paths cheap to reach. Frames use an extreme address, function 7 and a maximal count, so every field boundary and the CRC are covered.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  localparam int          FRAME_W    = 48;
  localparam logic [5:0]  XCMD_INDEX = 6'd53;
  localparam logic [6:0]  CRC_POLY   = 7'h09;   // x^7 + x^3 + 1, x^7 implied

  typedef struct packed {
    logic        wr;
    logic [2:0]  func;
    logic        blk;
    logic        inc;
    logic [16:0] addr;
    logic [8:0]  cnt;
  } sdx_desc_t;

  // Serial CRC7 over the 40 header bits, MSB first, register cleared at start.
  function automatic logic [6:0] crc7_calc(input logic [39:0] bits);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_pack(input sdx_desc_t d);
    logic [39:0] hdr;
    hdr = {1'b0, 1'b1, XCMD_INDEX, d.wr, d.func, d.blk, d.inc, d.addr, d.cnt};
    return {hdr, crc7_calc(hdr), 1'b1};
  endfunction

endpackage

// File: rtl/sdx_cmd_line.sv
module sdx_cmd_line
  import sdx_pkg::*;
#(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic               cmd_i,
  output logic               cmd_o,
  output logic               cmd_oe,
  output logic               rsp_ok,
  output logic               rsp_miss
);

  localparam int CMAX = (RESP_TIMEOUT > FRAME_W) ? RESP_TIMEOUT : FRAME_W;
  localparam int CW   = $clog2(CMAX) + 1;
  localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] LAST_SKIP = CW'(FRAME_W - 2);
  localparam logic [CW-1:0] LAST_WAIT = CW'(RESP_TIMEOUT - 1);

  typedef enum logic [2:0] {C_IDLE, C_PRE, C_SHIFT, C_POST, C_WAIT, C_SKIP} cst_t;

  cst_t               st;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;

  assign cmd_oe   = (st == C_PRE) || (st == C_SHIFT) || (st == C_POST);
  assign cmd_o    = (st == C_SHIFT) ? sh[FRAME_W-1] : 1'b1;
  assign rsp_ok   = (st == C_SKIP) && (cnt == LAST_SKIP);
  assign rsp_miss = (st == C_WAIT) && cmd_i && (cnt == LAST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= C_IDLE;
      sh  <= '0;
      cnt <= '0;
    end else begin
      unique case (st)
        C_IDLE: if (go) begin
          sh <= frame;
          st <= C_PRE;
        end
        C_PRE: begin
          cnt <= '0;
          st  <= C_SHIFT;
        end
        C_SHIFT: begin
          sh <= {sh[FRAME_W-2:0], 1'b0};
          if (cnt == LAST_BIT) st <= C_POST;
          else                 cnt <= cnt + 1'b1;
        end
        C_POST: begin
          cnt <= '0;
          st  <= C_WAIT;
        end
        C_WAIT: begin
          if (!cmd_i) begin
            cnt <= '0;
            st  <= C_SKIP;
          end else if (cnt == LAST_WAIT) begin
            st <= C_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_SKIP: begin
          if (cnt == LAST_SKIP) st <= C_IDLE;
          else                  cnt <= cnt + 1'b1;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdx_blk_tx.sv
module sdx_blk_tx #(
  parameter int BLK_F1      = 64,
  parameter int BLK_F2      = 512,
  parameter int ACK_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [8:0] nblk,
  input  logic       big,
  input  logic [7:0] pl_data,
  input  logic       dat0_i,
  output logic       pl_rd,
  output logic [3:0] dat_o,
  output logic [3:0] dat_oe,
  output logic       fin_ok,
  output logic       fin_err,
  output logic       blk_sbit,
  output logic       blk_ebit
);

  localparam int NMAX = 2 * ((BLK_F1 > BLK_F2) ? BLK_F1 : BLK_F2);
  localparam int NW   = $clog2(NMAX) + 1;
  localparam int TW   = $clog2(ACK_TIMEOUT) + 1;
  localparam logic [NW-1:0] LAST_N1 = NW'(2 * BLK_F1 - 1);
  localparam logic [NW-1:0] LAST_N2 = NW'(2 * BLK_F2 - 1);
  localparam logic [TW-1:0] LAST_TO = TW'(ACK_TIMEOUT - 1);
  localparam logic [TW-1:0] TOK_END = TW'(2);
  localparam logic [TW-1:0] GAP_END = TW'(1);
  localparam logic [2:0]    TOK_ACCEPT = 3'b010;

  typedef enum logic [2:0] {W_IDLE, W_HIGH, W_SBIT, W_DATA, W_EBIT, W_ACKW, W_ACKB, W_GAP} wst_t;

  wst_t          st;
  logic [NW-1:0] nib, nib_last;
  logic [8:0]    blk_left;
  logic [7:0]    byte_q;
  logic [2:0]    tok;
  logic [TW-1:0] tcnt;
  logic [2:0]    tok_now;
  logic          tok_done, ack_lost;

  assign tok_now  = {tok[1:0], dat0_i};
  assign tok_done = (st == W_ACKB) && (tcnt == TOK_END);
  assign ack_lost = (st == W_ACKW) && dat0_i && (tcnt == LAST_TO);
  assign fin_ok   = tok_done && (tok_now == TOK_ACCEPT) && (blk_left == 9'd0);
  assign fin_err  = (tok_done && (tok_now != TOK_ACCEPT)) || ack_lost;
  assign blk_sbit = (st == W_SBIT);
  assign blk_ebit = (st == W_EBIT);
  assign pl_rd    = (st == W_SBIT) || ((st == W_DATA) && nib[0] && (nib != nib_last));

  always_comb begin
    unique case (st)
      W_HIGH, W_SBIT, W_DATA, W_EBIT, W_GAP: dat_oe = 4'hF;
      W_ACKW, W_ACKB:                        dat_oe = 4'hE;
      default:                               dat_oe = 4'h0;
    endcase
    if (st == W_SBIT)      dat_o = 4'h0;
    else if (st == W_DATA) dat_o = nib[0] ? byte_q[3:0] : byte_q[7:4];
    else                   dat_o = 4'hF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      nib      <= '0;
      nib_last <= '0;
      blk_left <= '0;
      byte_q   <= '0;
      tok      <= '0;
      tcnt     <= '0;
    end else begin
      if (pl_rd) byte_q <= pl_data;
      unique case (st)
        W_IDLE: if (go) begin
          blk_left <= nblk;
          nib_last <= big ? LAST_N2 : LAST_N1;
          st       <= W_HIGH;
        end
        W_HIGH: st <= W_SBIT;
        W_SBIT: begin
          nib <= '0;
          st  <= W_DATA;
        end
        W_DATA: begin
          if (nib == nib_last) st <= W_EBIT;
          else                 nib <= nib + 1'b1;
        end
        W_EBIT: begin
          blk_left <= blk_left - 1'b1;
          tcnt     <= '0;
          st       <= W_ACKW;
        end
        W_ACKW: begin
          if (!dat0_i) begin
            tcnt <= '0;
            st   <= W_ACKB;
          end else if (ack_lost) begin
            st <= W_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        W_ACKB: begin
          tok <= tok_now;
          if (tok_done) begin
            tcnt <= '0;
            if (fin_ok || fin_err) st <= W_IDLE;
            else                   st <= W_GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        W_GAP: begin
          if (tcnt == GAP_END) st <= W_SBIT;
          else                 tcnt <= tcnt + 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdio_xcmd_gen.sv
module sdio_xcmd_gen
  import sdx_pkg::*;
#(
  parameter int BLK_F1       = 64,
  parameter int BLK_F2       = 512,
  parameter int RESP_TIMEOUT = 64,
  parameter int ACK_TIMEOUT  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        d_wr,
  input  logic [2:0]  d_func,
  input  logic        d_blk,
  input  logic        d_inc,
  input  logic [16:0] d_addr,
  input  logic [8:0]  d_cnt,
  input  logic [7:0]  pl_data,
  output logic        pl_rd,
  input  logic        cmd_i,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        dat0_i,
  output logic [3:0]  dat_o,
  output logic [3:0]  dat_oe,
  output logic        busy,
  output logic        done,
  output logic        err
);

  typedef enum logic [1:0] {T_IDLE, T_CMD, T_DATA} tst_t;

  tst_t      st;
  sdx_desc_t desc_in, desc_q;
  logic      reject, cmd_go, wr_go, data_phase;
  logic      rsp_ok, rsp_miss, fin_ok, fin_err, blk_sbit, blk_ebit;

  assign desc_in    = '{wr: d_wr, func: d_func, blk: d_blk, inc: d_inc, addr: d_addr, cnt: d_cnt};
  assign reject     = d_wr && d_blk && (d_cnt == 9'd0);
  assign cmd_go     = (st == T_IDLE) && start && !reject;
  assign data_phase = desc_q.wr && desc_q.blk;
  assign wr_go      = (st == T_CMD) && rsp_ok && data_phase;
  assign busy       = (st != T_IDLE);

  sdx_cmd_line #(.RESP_TIMEOUT(RESP_TIMEOUT)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (cmd_go),
    .frame    (frame_pack(desc_in)),
    .cmd_i    (cmd_i),
    .cmd_o    (cmd_o),
    .cmd_oe   (cmd_oe),
    .rsp_ok   (rsp_ok),
    .rsp_miss (rsp_miss)
  );

  sdx_blk_tx #(.BLK_F1(BLK_F1), .BLK_F2(BLK_F2), .ACK_TIMEOUT(ACK_TIMEOUT)) u_blk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (wr_go),
    .nblk     (desc_q.cnt),
    .big      (desc_q.func == 3'd2),
    .pl_data  (pl_data),
    .dat0_i   (dat0_i),
    .pl_rd    (pl_rd),
    .dat_o    (dat_o),
    .dat_oe   (dat_oe),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .blk_sbit (blk_sbit),
    .blk_ebit (blk_ebit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      desc_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        T_IDLE: if (start) begin
          desc_q <= desc_in;
          if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            st <= T_CMD;
          end
        end
        T_CMD: begin
          if (rsp_ok) begin
            if (data_phase) st <= T_DATA;
            else begin
              st   <= T_IDLE;
              done <= 1'b1;
              err  <= 1'b0;
            end
          end else if (rsp_miss) begin
            st   <= T_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        T_DATA: if (fin_ok || fin_err) begin
          st   <= T_IDLE;
          done <= 1'b1;
          err  <= fin_err;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdx_checker.sv
module sdx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        d_wr,
  input logic        d_blk,
  input logic [8:0]  d_cnt,
  input logic        cmd_o,
  input logic        cmd_oe,
  input logic [3:0]  dat_oe,
  input logic        done,
  input logic        err,
  input logic        blk_sbit,
  input logic        blk_ebit
);

  logic [6:0] oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_run <= '0;
    else if (cmd_oe) oe_run <= oe_run + 1'b1;
    else             oe_run <= '0;
  end

  AST_CMD_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cmd_oe) |-> oe_run == 7'd50); // R3
  AST_CMD_LEAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(cmd_oe) |-> cmd_o); // R3
  AST_CMD_START_BIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_oe && oe_run == 7'd1) |-> !cmd_o); // R1
  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && d_wr && d_blk && d_cnt == 9'd0) |=> (done && err && !cmd_oe)); // R11
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) done |-> (dat_oe == 4'h0 && !cmd_oe)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_OE_GROUPS: assert property (@(posedge clk) disable iff (!rst_n) (dat_oe == 4'h0 || dat_oe == 4'hE || dat_oe == 4'hF)); // R8
  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n) cmd_oe |-> dat_oe == 4'h0); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) blk_ebit |=> dat_oe == 4'hE); // R8
  AST_START_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) blk_sbit |-> $past(dat_oe) == 4'hF); // R6

endmodule

bind sdio_xcmd_gen sdx_checker u_sdx_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .d_wr     (d_wr),
  .d_blk    (d_blk),
  .d_cnt    (d_cnt),
  .cmd_o    (cmd_o),
  .cmd_oe   (cmd_oe),
  .dat_oe   (dat_oe),
  .done     (done),
  .err      (err),
  .blk_sbit (blk_sbit),
  .blk_ebit (blk_ebit)
);

// File: tb/sdio_xcmd_gen_bench.sv
module sdio_xcmd_gen_bench;

  localparam int BF1 = 4, BF2 = 8, RTO = 12, ATO = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0, d_wr = 1'b0, d_blk = 1'b0, d_inc = 1'b0;
  logic [2:0] d_func = '0;
  logic [16:0] d_addr = '0;
  logic [8:0] d_cnt = '0;
  logic cmd_i = 1'b1, dat0_i = 1'b1;
  logic [7:0] pl_data;
  logic pl_rd, cmd_o, cmd_oe, busy, done, err;
  logic [3:0] dat_o, dat_oe;

  int checks = 0, fails = 0;
  logic [7:0] payload [0:63];
  int pl_idx = 0;
  assign pl_data = payload[pl_idx[5:0]];

  logic [47:0] exp_frames[$];
  logic [7:0]  exp_bytes[$];
  int rsp_delay = 2, ack_delay = 1, ack_k = 0, cur_bytes = BF1;
  logic [2:0] toks [0:7];
  bit first_blk = 1'b1, dat_touched = 1'b0;
  int blocks_seen = 0, frames_seen = 0;

  sdio_xcmd_gen #(.BLK_F1(BF1), .BLK_F2(BF2), .RESP_TIMEOUT(RTO), .ACK_TIMEOUT(ATO)) u_sdio_xcmd_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .d_wr(d_wr), .d_func(d_func), .d_blk(d_blk),
    .d_inc(d_inc), .d_addr(d_addr), .d_cnt(d_cnt), .pl_data(pl_data), .pl_rd(pl_rd),
    .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .dat0_i(dat0_i), .dat_o(dat_o),
    .dat_oe(dat_oe), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Remainder by long division of header * x^7 by 0x89.
  function automatic logic [6:0] ref_crc(input logic [39:0] h);
    logic [46:0] v;
    v = {h, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v = v ^ (47'h89 << (i - 7));
    return v[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input bit wr, input logic [2:0] fn, input bit blk,
                                            input bit inc, input logic [16:0] a, input logic [8:0] c);
    logic [39:0] h;
    h = {2'b01, 6'b110101, wr, fn, blk, inc, a, c};
    return {h, ref_crc(h), 1'b1};
  endfunction

  // Payload source: advance after the edge that consumed the byte.
  initial forever begin
    @(negedge clk);
    if (pl_rd) begin
      @(posedge clk);
      #1 pl_idx++;
    end
  end

  // Command monitor and response model.
  initial begin
    logic [49:0] cap;
    logic [47:0] e;
    int n;
    cap = '0;
    n = 0;
    forever begin
      @(negedge clk);
      if (cmd_oe === 1'b1) begin
        cap = {cap[48:0], cmd_o};
        n++;
      end else if (n > 0) begin
        frames_seen++;
        chk(n == 50, "R3 cmd drive length", 64'(n), 64'd50);
        chk(cap[49] && cap[0], "R3 idle high around frame", {62'd0, cap[49], cap[0]}, 64'd3);
        if (exp_frames.size() == 0) chk(1'b0, "R1 unexpected frame", 64'(cap[48:1]), 64'd0);
        else begin
          e = exp_frames.pop_front();
          chk(cap[48:9] == e[47:8] && cap[1] == e[0], "R1 frame fields", 64'(cap[48:1]), 64'(e));
          chk(cap[8:2] == e[7:1], "R2 crc7", 64'(cap[8:2]), 64'(e[7:1]));
        end
        n = 0;
        if (rsp_delay >= 0) begin
          repeat (rsp_delay) @(negedge clk);
          cmd_i = 1'b0;
          @(negedge clk);
          cmd_i = 1'b1;
        end
      end
    end
  end

  // Data-line monitor: scoreboard for bytes, block framing and gaps.
  initial begin
    int hi_run, mode, nib, want;
    logic [7:0] b, eb;
    hi_run = 0; mode = 0; nib = 0; b = '0; eb = '0;
    forever begin
      @(negedge clk);
      if (dat_oe !== 4'h0) dat_touched = 1'b1;
      case (mode)
        0: begin
          if (dat_oe == 4'hF && dat_o == 4'hF) hi_run++;
          else if (dat_oe == 4'hF && dat_o == 4'h0) begin
            want = first_blk ? 1 : 2;
            chk(hi_run == want, first_blk ? "R6 lines high before first block" : "R9 idle clocks between blocks",
                64'(hi_run), 64'(want));
            first_blk = 1'b0;
            mode = 1;
            nib = 0;
          end else hi_run = 0;
        end
        1: begin
          chk(dat_oe == 4'hF, "R6 lines driven in block", 64'(dat_oe), 64'hF);
          if (nib % 2 == 0) b[7:4] = dat_o;
          else begin
            b[3:0] = dat_o;
            if (exp_bytes.size() == 0) chk(1'b0, "R7 extra payload byte", 64'(b), 64'd0);
            else begin
              eb = exp_bytes.pop_front();
              chk(b == eb, "R6 R7 payload byte", 64'(b), 64'(eb));
            end
          end
          nib++;
          if (nib == 2 * cur_bytes) mode = 2;
        end
        default: begin
          chk(dat_oe == 4'hF && dat_o == 4'hF, "R6 end nibble", 64'({dat_oe, dat_o}), 64'hFF);
          blocks_seen++;
          hi_run = 0;
          mode = 0;
        end
      endcase
    end
  end

  // Acknowledgement token model on data line 0.
  initial begin
    bit prev_e;
    prev_e = 1'b0;
    forever begin
      @(negedge clk);
      if (dat_oe == 4'hE && !prev_e) begin
        if (ack_delay >= 0) begin
          repeat (ack_delay) @(negedge clk);
          dat0_i = 1'b0;
          for (int j = 2; j >= 0; j--) begin
            @(negedge clk);
            dat0_i = toks[ack_k[2:0]][j];
          end
          @(negedge clk);
          dat0_i = 1'b1;
        end
        ack_k++;
      end
      prev_e = (dat_oe == 4'hE);
    end
  end

  // Driver: pushes expected frame and bytes, launches, waits, checks outcome.
  task automatic run(input bit wr, input logic [2:0] fn, input bit blk, input bit inc,
                     input logic [16:0] a, input logic [8:0] c, input int nblk_tx,
                     input bit err_exp, input bit expect_data, input string tag);
    int nbytes;
    bit got;
    nbytes = (fn == 3'd2) ? BF2 : BF1;
    cur_bytes = nbytes; first_blk = 1'b1; blocks_seen = 0; frames_seen = 0;
    dat_touched = 1'b0; ack_k = 0; pl_idx = 0;
    exp_bytes.delete();
    exp_frames.delete();
    for (int i = 0; i < 64; i++) payload[i] = 8'((i * 37 + 5 + int'(a[7:0])) % 256);
    if (!(wr && blk && c == 9'd0)) exp_frames.push_back(ref_frame(wr, fn, blk, inc, a, c));
    for (int i = 0; i < nblk_tx * nbytes; i++) exp_bytes.push_back(payload[i]);
    @(negedge clk);
    d_wr = wr; d_func = fn; d_blk = blk; d_inc = inc; d_addr = a; d_cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 3000 && !got; k++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, {tag, " done within watchdog"}, 64'(got), 64'd1);
    chk(err == err_exp, {tag, " err flag"}, 64'(err), 64'(err_exp));
    repeat (4) @(negedge clk);
    chk(blocks_seen == nblk_tx, {tag, " blocks on data lines"}, 64'(blocks_seen), 64'(nblk_tx));
    chk(dat_oe == 4'h0, "R10 data lines released", 64'(dat_oe), 64'd0);
    chk(exp_frames.size() == 0, {tag, " frame emitted"}, 64'(exp_frames.size()), 64'd0);
    chk(exp_bytes.size() == 0, {tag, " all bytes sent"}, 64'(exp_bytes.size()), 64'd0);
    if (!expect_data) chk(!dat_touched, {tag, " data lines untouched"}, 64'(dat_touched), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) toks[i] = 3'b010;
    repeat (3) @(negedge clk);
    chk(cmd_oe == 1'b0 && dat_oe == 4'h0 && !busy && !done, "R10 reset state",
        64'({cmd_oe, dat_oe, busy, done}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: read, byte mode, backplane-style address
    rsp_delay = 2;
    run(1'b0, 3'd1, 1'b0, 1'b1, 17'h1000A, 9'd4, 0, 1'b0, 1'b0, "R5 byte read");
    // R1 R2: extreme field values, write in byte mode
    rsp_delay = 0;
    run(1'b1, 3'd7, 1'b0, 1'b0, 17'h1FFFF, 9'h1FF, 0, 1'b0, 1'b0, "R5 R1 byte write");
    // R6 R8 R9 R10: two accepted blocks, function 1
    rsp_delay = 3; ack_delay = 1;
    run(1'b1, 3'd1, 1'b1, 1'b1, 17'h08000, 9'd2, 2, 1'b0, 1'b1, "R6 R9 two blocks");
    // R7: function 2 selects the larger block
    ack_delay = 0;
    run(1'b1, 3'd2, 1'b1, 1'b0, 17'h00040, 9'd1, 1, 1'b0, 1'b1, "R7 func2 block");
    // R8: three blocks, second token rejected
    ack_delay = 2; toks[1] = 3'b101;
    run(1'b1, 3'd1, 1'b1, 1'b1, 17'h0FD54, 9'd3, 2, 1'b1, 1'b1, "R8 token reject");
    toks[1] = 3'b010;
    // R8: no token start bit
    ack_delay = -1;
    run(1'b1, 3'd0, 1'b1, 1'b0, 17'h00001, 9'd1, 1, 1'b1, 1'b1, "R8 token timeout");
    ack_delay = 1;
    // R4: no command response
    rsp_delay = -1;
    run(1'b1, 3'd1, 1'b1, 1'b1, 17'h00100, 9'd2, 0, 1'b1, 1'b0, "R4 no response");
    rsp_delay = 1;
    // R11: zero count in block write
    run(1'b1, 3'd1, 1'b1, 1'b0, 17'h00200, 9'd0, 0, 1'b1, 1'b0, "R11 zero count");
    chk(frames_seen == 0, "R11 no frame sent", 64'(frames_seen), 64'd0);
    // R5 after error paths: recovery with a read
    run(1'b0, 3'd2, 1'b1, 1'b1, 17'h00003, 9'd0, 0, 1'b0, 1'b0, "R5 block read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule